// File: doc/BRIEF.md
# Clock Generator Mode Controller

This controller decides which operating mode an on-chip clock generator runs in. There are five modes: off, self-clocked, FLL locked to the internal reference, external clock bypassing the FLL, and FLL locked to the external clock. Software writes a two-bit select field. The controller combines that field with a stop request, wake events, a debug enable, an option that keeps the oscillator running during stop, a DCO-stable flag and its own qualification of the external clock. From these it drives the mode, the gate that feeds the generated clock to the rest of the chip, and the choice of reference.

The external clock arrives on `ext_clk_i`. It is synchronised and its rising edges are counted: the clock counts as present only after a fixed number of edges. A watchdog, clocked by the internal reference on `clk_i`, raises a sticky loss-of-clock flag when the edges stop. Stop and wake follow the cause of each event. Debug overrides stop entirely. The keep-oscillator option holds qualification while the output gate is closed. An interrupt wake keeps the programmed select field. A reset returns every setting to its default.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: After reset the mode is self-clocked (code 1), the select field is 00, the clock gate is open, the reference select is internal (0), and both the present flag and the loss flag are low.
- R2: A write with `sel_wr_i` stores `sel_i`. When not stopped and no override applies, select 00 gives self-clocked (1), 01 gives FLL internal (2), 10 gives bypass external (3) and 11 gives FLL external (4). Writing 00 after 01 or 11 returns the mode to self-clocked.
- R3: `ext_present_o` rises only after QUAL_EDGES (default 4096) rising edges of `ext_clk_i` have been counted while the oscillator is enabled.
- R4: In bypass external mode the clock gate stays closed until the external clock is present. In FLL external mode the reference select stays internal (0) until the external clock is present, and becomes 1 afterwards.
- R5: A stop request without debug gives mode off (0), a closed gate and an internal reference. If the keep-oscillator option is clear, the oscillator is powered down and qualification is lost.
- R6: While `dbg_en_i` is high, a stop request has no effect and the mode stays as programmed.
- R7: With `osc_stop_en_i` high during stop, the mode is off and the gate is closed, but the external clock stays qualified. On wake, bypass external reopens the gate without requalifying.
- R8: An interrupt wake (`wake_irq_i`) leaves stop and keeps the programmed select field.
- R9: On an interrupt wake with select bit 0 set while `dco_stable_i` is low, the mode is held at self-clocked until `dco_stable_i` goes high.
- R10: A reset during stop returns the mode to self-clocked and the select field to 00.
- R11: With select 1x and the oscillator enabled, LOSS_WIN (default 64) internal cycles without an external rising edge set the loss flag, clear the present flag and force the mode to self-clocked.
- R12: The loss flag stays set until the next select write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Clock select value |
| sel_wr_i | input | 1 | Write strobe for the select field |
| stop_req_i | input | 1 | Request to enter stop |
| wake_irq_i | input | 1 | Interrupt wake from stop |
| dbg_en_i | input | 1 | Debug enable, overrides stop |
| osc_stop_en_i | input | 1 | Keep oscillator running in stop |
| dco_stable_i | input | 1 | DCO stable flag |
| ext_clk_i | input | 1 | External clock qualifier input |
| mode_o | output | 3 | Current mode code (0 off, 1 self, 2 FLL int, 3 bypass ext, 4 FLL ext) |
| clk_gate_o | output | 1 | Output clock gate open |
| ref_sel_ext_o | output | 1 | Reference source is external |
| ext_present_o | output | 1 | External clock qualified |
| loss_of_clk_o | output | 1 | Sticky loss-of-clock flag |

## Verification
The assertions check four rules on every cycle. A stop request without debug or wake leads to off on the next cycle. Debug keeps the mode out of off. A rising loss flag pulls the mode to off or self-clocked. The loss flag holds until a select write. The bench scenarios cover the rest: the 4096-edge qualification boundary, and requalification after stop with the oscillator powered down compared with the keep-oscillator case. They also cover holding self-clocked until the DCO is stable after wake, and the defaults restored by a reset during stop, because each of these spans thousands of cycles or depends on history.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_SELF    = 3'd1,
    MODE_FLL_INT = 3'd2,
    MODE_BYP_EXT = 3'd3,
    MODE_FLL_EXT = 3'd4
  } mode_e;

  localparam logic [1:0] SEL_SELF    = 2'b00;
  localparam logic [1:0] SEL_FLL_INT = 2'b01;
  localparam logic [1:0] SEL_BYP_EXT = 2'b10;
  localparam logic [1:0] SEL_FLL_EXT = 2'b11;

endpackage

// File: rtl/clkgen_ext_qual.sv
module clkgen_ext_qual #(
  parameter int unsigned QUAL_EDGES  = 4096,
  parameter int unsigned LOSS_WIN    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic osc_on_i,
  input  logic watch_en_i,
  input  logic restart_i,
  output logic present_o,
  output logic loss_o
);

  localparam int unsigned QW = $clog2(QUAL_EDGES + 1);
  localparam int unsigned LW = $clog2(LOSS_WIN + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_EDGES - 1);
  localparam logic [LW-1:0] WD_LAST   = LW'(LOSS_WIN - 1);
  localparam logic [LW-1:0] WD_SAT    = LW'(LOSS_WIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise;
  logic [QW-1:0]          cnt_q, cnt_d;
  logic [LW-1:0]          wd_q, wd_d;
  logic                   pres_q, pres_d;
  logic                   loss_q, loss_d;
  logic                   timeout;

  // synchroniser chain for the external clock sample
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= ext_clk_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

  // watchdog: internal cycles since the last external edge
  always_comb begin
    wd_d    = wd_q;
    timeout = 1'b0;
    if (!osc_on_i || !watch_en_i || rise || restart_i) begin
      wd_d = '0;
    end else if (wd_q == WD_LAST) begin
      timeout = 1'b1;
      wd_d    = WD_SAT;
    end else if (wd_q != WD_SAT) begin
      wd_d = wd_q + 1'b1;
    end
  end

  // edge counter that qualifies the crystal
  always_comb begin
    cnt_d  = cnt_q;
    pres_d = pres_q;
    if (!osc_on_i || timeout) begin
      cnt_d  = '0;
      pres_d = 1'b0;
    end else if (rise && !pres_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == QUAL_LAST) pres_d = 1'b1;
    end
  end

  always_comb begin
    loss_d = loss_q;
    if (restart_i)    loss_d = 1'b0;
    else if (timeout) loss_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      cnt_q  <= '0;
      wd_q   <= '0;
      pres_q <= 1'b0;
      loss_q <= 1'b0;
    end else begin
      last_q <= sync_q[SYNC_STAGES-1];
      cnt_q  <= cnt_d;
      wd_q   <= wd_d;
      pres_q <= pres_d;
      loss_q <= loss_d;
    end
  end

  assign present_o = pres_q;
  assign loss_o    = loss_q;

endmodule

// File: rtl/clkgen_stop_ctrl.sv
module clkgen_stop_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic wake_irq_i,
  input  logic dbg_en_i,
  input  logic sel_b0_i,
  input  logic dco_stable_i,
  output logic stop_o,
  output logic off_next_o,
  output logic dco_wait_next_o
);

  logic stop_q, stop_d;
  logic dwait_q, dwait_d;
  logic wake;

  assign wake = stop_q & wake_irq_i;

  always_comb begin
    if (stop_q) stop_d = ~wake_irq_i;
    else        stop_d = stop_req_i & ~dbg_en_i;
  end

  always_comb begin
    dwait_d = dwait_q;
    if (wake && sel_b0_i && !dco_stable_i) dwait_d = 1'b1;
    else if (dco_stable_i)                 dwait_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q  <= 1'b0;
      dwait_q <= 1'b0;
    end else begin
      stop_q  <= stop_d;
      dwait_q <= dwait_d;
    end
  end

  assign stop_o          = stop_q;
  assign off_next_o      = stop_d & ~dbg_en_i;
  assign dco_wait_next_o = dwait_d;

endmodule

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
  import clkgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       off_i,
  input  logic       dco_wait_i,
  input  logic       present_i,
  input  logic       loss_i,
  output logic [2:0] mode_o,
  output logic       clk_gate_o,
  output logic       ref_ext_o
);

  mode_e mode_q, mode_d;
  logic  no_ext;

  assign no_ext = loss_i & ~present_i;

  always_comb begin
    mode_d = mode_q;
    if (off_i) begin
      mode_d = MODE_OFF;
    end else begin
      case (sel_i)
        SEL_SELF:    mode_d = MODE_SELF;
        SEL_FLL_INT: mode_d = dco_wait_i ? MODE_SELF : MODE_FLL_INT;
        SEL_BYP_EXT: mode_d = (no_ext || dco_wait_i) ? MODE_SELF : MODE_BYP_EXT;
        default:     mode_d = (no_ext || dco_wait_i) ? MODE_SELF : MODE_FLL_EXT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SELF;
    else         mode_q <= mode_d;
  end

  always_comb begin
    case (mode_q)
      MODE_OFF:     clk_gate_o = 1'b0;
      MODE_BYP_EXT: clk_gate_o = present_i;
      default:      clk_gate_o = 1'b1;
    endcase
  end

  assign ref_ext_o = ((mode_q == MODE_BYP_EXT) || (mode_q == MODE_FLL_EXT)) & present_i;
  assign mode_o    = mode_q;

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl #(
  parameter int unsigned QUAL_EDGES  = 4096,
  parameter int unsigned LOSS_WIN    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       sel_wr_i,
  input  logic       stop_req_i,
  input  logic       wake_irq_i,
  input  logic       dbg_en_i,
  input  logic       osc_stop_en_i,
  input  logic       dco_stable_i,
  input  logic       ext_clk_i,
  output logic [2:0] mode_o,
  output logic       clk_gate_o,
  output logic       ref_sel_ext_o,
  output logic       ext_present_o,
  output logic       loss_of_clk_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic [1:0] sel_q;
  logic       stop_q;
  logic       off_next;
  logic       dco_wait_next;
  logic       osc_on;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        sel_q <= 2'b00;
    else if (sel_wr_i) sel_q <= sel_i;
  end

  assign osc_on = sel_q[1] & (~stop_q | osc_stop_en_i | dbg_en_i);

  clkgen_stop_ctrl u_stop (
    .clk_i           (clk_i),
    .rst_ni          (rst_n),
    .stop_req_i      (stop_req_i),
    .wake_irq_i      (wake_irq_i),
    .dbg_en_i        (dbg_en_i),
    .sel_b0_i        (sel_q[0]),
    .dco_stable_i    (dco_stable_i),
    .stop_o          (stop_q),
    .off_next_o      (off_next),
    .dco_wait_next_o (dco_wait_next)
  );

  clkgen_ext_qual #(
    .QUAL_EDGES  (QUAL_EDGES),
    .LOSS_WIN    (LOSS_WIN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ext_clk_i  (ext_clk_i),
    .osc_on_i   (osc_on),
    .watch_en_i (sel_q[1]),
    .restart_i  (sel_wr_i),
    .present_o  (ext_present_o),
    .loss_o     (loss_of_clk_o)
  );

  clkgen_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sel_i      (sel_q),
    .off_i      (off_next),
    .dco_wait_i (dco_wait_next),
    .present_i  (ext_present_o),
    .loss_i     (loss_of_clk_o),
    .mode_o     (mode_o),
    .clk_gate_o (clk_gate_o),
    .ref_ext_o  (ref_sel_ext_o)
  );

endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk
  import clkgen_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_wr_i,
  input logic       stop_req_i,
  input logic       wake_irq_i,
  input logic       dbg_en_i,
  input logic [2:0] mode_o,
  input logic       loss_of_clk_o
);

  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_stop_to_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    stop_req_i && !dbg_en_i && !wake_irq_i |=> mode_o == MODE_OFF);

  assert_debug_keeps_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    dbg_en_i |=> mode_o != MODE_OFF);

  assert_loss_forces_self_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    $rose(loss_of_clk_o) |=> (mode_o == MODE_OFF) || (mode_o == MODE_SELF));

  assert_loss_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    loss_of_clk_o && !sel_wr_i |=> loss_of_clk_o);

endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_wr_i      (sel_wr_i),
  .stop_req_i    (stop_req_i),
  .wake_irq_i    (wake_irq_i),
  .dbg_en_i      (dbg_en_i),
  .mode_o        (mode_o),
  .loss_of_clk_o (loss_of_clk_o)
);

// File: tb/clkgen_mode_ctrl_tb.sv
module clkgen_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QUAL_WAIT_LO = 8170;
  localparam int QUAL_WAIT_HI = 40;

  // {sel[1:0], wait[7:0], mode[2:0], gate, ref, present, loss}
  localparam int NV = 5;
  localparam logic [16:0] VEC [NV] = '{
    {2'b01, 8'd4,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b00, 8'd4,  3'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b11, 8'd90, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b10, 8'd4,  3'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b01, 8'd4,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic [1:0] sel;
  logic       sel_wr, stop_req, wake_irq, dbg_en, osc_stop_en, dco_stable;
  logic       ext_clk, ext_run;
  logic [2:0] mode;
  logic       gate, ref_ext, present, loss;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  clkgen_mode_ctrl u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sel_i         (sel),
    .sel_wr_i      (sel_wr),
    .stop_req_i    (stop_req),
    .wake_irq_i    (wake_irq),
    .dbg_en_i      (dbg_en),
    .osc_stop_en_i (osc_stop_en),
    .dco_stable_i  (dco_stable),
    .ext_clk_i     (ext_clk),
    .mode_o        (mode),
    .clk_gate_o    (gate),
    .ref_sel_ext_o (ref_ext),
    .ext_present_o (present),
    .loss_of_clk_o (loss)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial ext_clk = 1'b0;
  always @(negedge clk) if (ext_run) ext_clk <= ~ext_clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic write_sel(input logic [1:0] v);
    @(negedge clk);
    sel = v; sel_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    sel = 2'b00; sel_wr = 0; stop_req = 0; wake_irq = 0; dbg_en = 0;
    osc_stop_en = 0; dco_stable = 1; ext_run = 0; rst_n = 0;
    step(4);
    rst_n = 1;
    step(4);

    // R1 reset state
    check("R1", "mode", mode, 1);
    check("R1", "gate", gate, 1);
    check("R1", "ref", ref_ext, 0);
    check("R1", "present", present, 0);
    check("R1", "loss", loss, 0);

    // R2 R11 R12 select decoding and loss with no external clock
    for (int v = 0; v < NV; v++) begin
      write_sel(VEC[v][16:15]);
      step(int'(VEC[v][14:7]));
      check("R2 R11", "mode", mode, int'(VEC[v][6:4]));
      check("R2 R4", "gate", gate, int'(VEC[v][3]));
      check("R2 R4", "ref", ref_ext, int'(VEC[v][2]));
      check("R3", "present", present, int'(VEC[v][1]));
      check("R11 R12", "loss", loss, int'(VEC[v][0]));
    end

    // R3 R4 qualification boundary in bypass external
    ext_run = 1;
    write_sel(2'b10);
    step(QUAL_WAIT_LO);
    check("R3", "present early", present, 0);
    check("R4", "gate before qualify", gate, 0);
    step(QUAL_WAIT_HI);
    check("R3", "present after edges", present, 1);
    check("R4", "gate after qualify", gate, 1);
    check("R4", "ref bypass", ref_ext, 1);
    check("R2", "mode bypass", mode, 3);

    // R7 keep-oscillator stop holds qualification
    osc_stop_en = 1;
    pulse_stop();
    step(3);
    check("R7", "mode stop", mode, 0);
    check("R7", "gate stop", gate, 0);
    check("R7", "present kept", present, 1);
    pulse_wake();
    step(2);
    osc_stop_en = 0;
    check("R7 R8", "mode wake", mode, 3);
    check("R7", "gate wake", gate, 1);

    // R6 debug overrides stop
    dbg_en = 1;
    pulse_stop();
    step(3);
    check("R6", "mode debug", mode, 3);
    check("R6", "gate debug", gate, 1);
    dbg_en = 0;
    step(2);
    check("R6", "mode after debug", mode, 3);

    // R5 R8 stop without keep-oscillator, wake needs requalify
    pulse_stop();
    step(3);
    check("R5", "mode stop", mode, 0);
    check("R5", "gate stop", gate, 0);
    check("R5", "ref stop", ref_ext, 0);
    check("R5", "present lost", present, 0);
    pulse_wake();
    step(3);
    check("R8", "mode wake", mode, 3);
    check("R4", "gate requalify", gate, 0);
    step(QUAL_WAIT_LO + QUAL_WAIT_HI);
    check("R4", "gate requalified", gate, 1);

    // R9 R4 FLL external wake with DCO not yet stable
    write_sel(2'b11);
    step(3);
    check("R2", "mode fll ext", mode, 4);
    check("R4", "ref fll ext", ref_ext, 1);
    pulse_stop();
    step(3);
    dco_stable = 0;
    pulse_wake();
    step(5);
    check("R9", "held self", mode, 1);
    dco_stable = 1;
    step(3);
    check("R9 R8", "mode after dco", mode, 4);
    check("R4", "ref internal until qualify", ref_ext, 0);
    check("R4", "gate fll ext", gate, 1);
    step(QUAL_WAIT_LO + QUAL_WAIT_HI);
    check("R4", "ref external", ref_ext, 1);

    // R11 R12 loss while running
    ext_run = 0;
    step(100);
    check("R11", "loss set", loss, 1);
    check("R11", "present cleared", present, 0);
    check("R11", "mode self", mode, 1);
    step(50);
    check("R12", "loss sticky", loss, 1);

    // R10 reset during stop
    pulse_stop();
    step(3);
    check("R5", "mode stop again", mode, 0);
    @(negedge clk); rst_n = 0;
    step(3);
    rst_n = 1;
    step(5);
    check("R10", "mode after reset", mode, 1);
    check("R10", "loss after reset", loss, 0);
    check("R10", "gate after reset", gate, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule